// File: doc/BRIEF.md
# Motor Drive Safety Interlock

This block sits between a motion-control loop and the digital-to-analog converter that feeds a motor drive. While no fault is latched, it forwards the signed drive command from the loop after one register stage. It watches five trip conditions:

- the low and high end-of-travel switches;
- measured speed above a configured ceiling;
- a command magnitude above a configured ceiling;
- the gap between two encoder position counts growing larger than a fixed limit.

Any trip sets its own sticky bit in a five-bit fault word and forces the command to zero. The command stays at zero until a clear pulse arrives in a cycle in which no trip condition is active. This holds even after the original condition has gone away.

The end-of-travel inputs come from mechanical switches, so each one passes through a synchronizer chain before it is judged. A single-encoder plant has no second position count to compare, so it turns the position-gap check off with a configuration input. Encoder decoding, speed estimation, the converter interface and the source of the clear pulse all live outside the block.

Top module: `motor_interlock`

## Requirements
- R1: While `rst` is high at a rising edge, the block behaves as follows from that edge on:
  - `fault_word` is 0;
  - `cmd_out` is 0;
  - `tripped` is 0;
  - the switch synchronizers are emptied.
- R2: With `fault_word` at 0 and no trip condition active, `cmd_out` shows the `cmd_in` value sampled at the previous rising edge.
- R3: A switch input is sampled high at some edge. At the second rising edge after that one, the block sets its fault bit (`lim_lo_raw` is bit 0, `lim_hi_raw` is bit 1) and `cmd_out` becomes 0.
- R4: `speed_in` is compared with `speed_limit` as unsigned values. If it is strictly greater at an edge, bit 2 is set and `cmd_out` is 0 from that edge on. Equality does not trip.
- R5: The magnitude of the signed command is compared with the unsigned `volt_limit`, with -32768 taken as magnitude 32768. If the magnitude is strictly greater at an edge, bit 3 is set and `cmd_out` is 0 from that edge on.
- R6: The absolute difference between signed `pos_a` and `pos_b` is compared with 3000. If `rel_check_en` is 1 and the difference is strictly greater, bit 4 is set and `cmd_out` is 0. A difference of exactly 3000 does not trip. With `rel_check_en` at 0, the difference has no effect.
- R7: Once set, a fault bit stays set and `cmd_out` stays 0 until a clear pulse succeeds. This holds even after the trip condition has disappeared.
- R8: If `clear` is high at an edge where no trip condition is active, every fault bit is reset at that edge. `cmd_out` then carries that edge's `cmd_in` value.
- R9: If `clear` is high at an edge where any trip condition is active, the clear is ignored. Held bits stay set, and newly active sources are added.
- R10: Conditions that are active at the same edge each set their own bit at that edge.
- R11: `tripped` is 1 exactly when `fault_word` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lim_lo_raw | input | 1 | Low end-of-travel switch, asynchronous |
| lim_hi_raw | input | 1 | High end-of-travel switch, asynchronous |
| rel_check_en | input | 1 | Enables the two-encoder gap check |
| clear | input | 1 | Fault clear request |
| speed_limit | input | 16 | Unsigned speed ceiling |
| volt_limit | input | 16 | Unsigned command-magnitude ceiling |
| cmd_in | input | 16 | Signed drive command from the loop |
| speed_in | input | 16 | Unsigned measured speed |
| pos_a | input | 32 | Signed first encoder count |
| pos_b | input | 32 | Signed second encoder count |
| cmd_out | output | 16 | Gated signed command to the converter |
| fault_word | output | 5 | Sticky trip causes |
| tripped | output | 1 | Any fault latched |

## Verification
A clear request can land in the same cycle as a live trip condition. It can also land in the same cycle as a fresh trip from a different source. The bench creates both cases:

- it holds speed above its ceiling and pulses `clear`;
- it asserts a switch two cycles ahead, so that the synchronized value arrives together with an overspeed and with a clear.

A behavioural model decides each cycle whether the clear wins. The bench compares `fault_word`, `tripped` and `cmd_out` with that model at every cycle.

// File: rtl/mi_pkg.sv
package mi_pkg;
   localparam int NFAULT   = 5;
   localparam int F_LIM_LO = 0;
   localparam int F_LIM_HI = 1;
   localparam int F_SPEED  = 2;
   localparam int F_VOLT   = 3;
   localparam int F_GAP    = 4;
   typedef logic [NFAULT-1:0] fault_vec_t;
endpackage

// File: rtl/mi_sync.sv
module mi_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mi_sync needs at least two stages");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("mi_sync needs a nonzero width");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) begin
            chain[s] <= '0;
         end else begin
            if (s == 0) chain[s] <= d_async;
            else        chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/mi_trip_detect.sv
module mi_trip_detect
   import mi_pkg::*;
#(
   parameter int CMD_W             = 16,
   parameter int SPD_W             = 16,
   parameter int POS_W             = 32,
   parameter int REL_LIMIT         = 3000,
   parameter bit REL_CHECK_PRESENT = 1'b1
) (
   input  logic [1:0]       lim_sync,
   input  logic             rel_check_en,
   input  logic [SPD_W-1:0] speed_limit,
   input  logic [CMD_W-1:0] volt_limit,
   input  logic [CMD_W-1:0] cmd_in,
   input  logic [SPD_W-1:0] speed_in,
   input  logic [POS_W-1:0] pos_a,
   input  logic [POS_W-1:0] pos_b,
   output fault_vec_t       trip_now
);
   localparam logic [POS_W:0] GAP_LIM = (POS_W+1)'(REL_LIMIT);

   if (CMD_W < 2) begin : g_bad_cmd
      $error("command width too small");
   end
   if (REL_LIMIT < 0) begin : g_bad_rel
      $error("relative limit must be non-negative");
   end

   logic signed [CMD_W:0] cmd_ext;
   logic        [CMD_W:0] cmd_mag;
   logic                  volt_over;
   logic                  speed_over;
   logic                  gap_over;

   always_comb begin
      cmd_ext   = {cmd_in[CMD_W-1], cmd_in};
      cmd_mag   = cmd_ext[CMD_W] ? -cmd_ext : cmd_ext;
      volt_over = cmd_mag > {1'b0, volt_limit};
   end

   assign speed_over = speed_in > speed_limit;

   if (REL_CHECK_PRESENT) begin : g_gap
      logic signed [POS_W:0] gap_diff;
      logic        [POS_W:0] gap_mag;
      always_comb begin
         gap_diff = {pos_a[POS_W-1], pos_a} - {pos_b[POS_W-1], pos_b};
         gap_mag  = gap_diff[POS_W] ? -gap_diff : gap_diff;
         gap_over = rel_check_en && (gap_mag > GAP_LIM);
      end
   end else begin : g_no_gap
      assign gap_over = 1'b0;
   end

   always_comb begin
      trip_now           = '0;
      trip_now[F_LIM_LO] = lim_sync[0];
      trip_now[F_LIM_HI] = lim_sync[1];
      trip_now[F_SPEED]  = speed_over;
      trip_now[F_VOLT]   = volt_over;
      trip_now[F_GAP]    = gap_over;
   end
endmodule

// File: rtl/mi_fault_latch.sv
module mi_fault_latch
   import mi_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       clear,
   input  fault_vec_t trip_now,
   output fault_vec_t fault_q,
   output fault_vec_t fault_next
);
   always_comb begin
      if (clear && (trip_now == '0)) fault_next = '0;
      else                           fault_next = fault_q | trip_now;
   end

   always_ff @(posedge clk) begin
      if (rst) fault_q <= '0;
      else     fault_q <= fault_next;
   end

   for (genvar i = 0; i < NFAULT; i++) begin : g_sticky_chk
      assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
         (fault_q[i] && !clear) |=> fault_q[i]);
   end

   assert_clear_blocked_R9: assert property (@(posedge clk) disable iff (rst)
      (clear && (trip_now != '0)) |=> (fault_q != '0));

   assert_clear_ok_R8: assert property (@(posedge clk) disable iff (rst)
      (clear && (trip_now == '0)) |=> (fault_q == '0));

   assert_each_bit_R10: assert property (@(posedge clk) disable iff (rst)
      (trip_now != '0) |=> ((fault_q & $past(trip_now)) == $past(trip_now)));
endmodule

// File: rtl/motor_interlock.sv
module motor_interlock
   import mi_pkg::*;
#(
   parameter int CMD_W             = 16,
   parameter int SPD_W             = 16,
   parameter int POS_W             = 32,
   parameter int REL_LIMIT         = 3000,
   parameter int SYNC_STAGES       = 2,
   parameter bit REL_CHECK_PRESENT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    lim_lo_raw,
   input  logic                    lim_hi_raw,
   input  logic                    rel_check_en,
   input  logic                    clear,
   input  logic [SPD_W-1:0]        speed_limit,
   input  logic [CMD_W-1:0]        volt_limit,
   input  logic signed [CMD_W-1:0] cmd_in,
   input  logic [SPD_W-1:0]        speed_in,
   input  logic signed [POS_W-1:0] pos_a,
   input  logic signed [POS_W-1:0] pos_b,
   output logic signed [CMD_W-1:0] cmd_out,
   output logic [NFAULT-1:0]       fault_word,
   output logic                    tripped
);
   if (POS_W < 2) begin : g_bad_pos
      $error("position width too small");
   end

   logic [1:0]  lim_sync;
   fault_vec_t  trip_now;
   fault_vec_t  fault_q;
   fault_vec_t  fault_next;

   mi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async ({lim_hi_raw, lim_lo_raw}),
      .d_sync  (lim_sync)
   );

   mi_trip_detect #(
      .CMD_W(CMD_W), .SPD_W(SPD_W), .POS_W(POS_W),
      .REL_LIMIT(REL_LIMIT), .REL_CHECK_PRESENT(REL_CHECK_PRESENT)
   ) u_detect (
      .lim_sync     (lim_sync),
      .rel_check_en (rel_check_en),
      .speed_limit  (speed_limit),
      .volt_limit   (volt_limit),
      .cmd_in       (cmd_in),
      .speed_in     (speed_in),
      .pos_a        (pos_a),
      .pos_b        (pos_b),
      .trip_now     (trip_now)
   );

   mi_fault_latch u_latch (
      .clk        (clk),
      .rst        (rst),
      .clear      (clear),
      .trip_now   (trip_now),
      .fault_q    (fault_q),
      .fault_next (fault_next)
   );

   always_ff @(posedge clk) begin
      if (rst)                     cmd_out <= '0;
      else if (fault_next != '0)   cmd_out <= '0;
      else                         cmd_out <= cmd_in;
   end

   assign fault_word = fault_q;
   assign tripped    = |fault_q;

   assert_reset_R1: assert property (@(posedge clk)
      rst |=> (fault_word == '0 && cmd_out == '0));

   assert_pass_R2: assert property (@(posedge clk) disable iff (rst)
      (trip_now == '0 && fault_q == '0) |=> (cmd_out == $past(cmd_in)));

   assert_limit_trip_R3: assert property (@(posedge clk) disable iff (rst)
      (lim_sync != 2'b00) |=> (fault_word[F_LIM_LO] | fault_word[F_LIM_HI]));

   assert_speed_trip_R4: assert property (@(posedge clk) disable iff (rst)
      (speed_in > speed_limit) |=> (fault_word[F_SPEED] && cmd_out == '0));

   assert_zero_out_R7: assert property (@(posedge clk) disable iff (rst)
      (fault_word != '0) |-> (cmd_out == '0));
endmodule

// File: tb/motor_interlock_bench.sv
module motor_interlock_bench;
   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               lim_lo_raw = 1'b0, lim_hi_raw = 1'b0;
   logic               rel_check_en = 1'b1, clear = 1'b0;
   logic [15:0]        speed_limit = 16'd1000, volt_limit = 16'd20000;
   logic signed [15:0] cmd_in = '0;
   logic [15:0]        speed_in = '0;
   logic signed [31:0] pos_a = '0, pos_b = '0;
   logic signed [15:0] cmd_out;
   logic [4:0]         fault_word;
   logic               tripped;

   int vectors = 0;
   int miscompares = 0;

   int m_fault = 0;
   int m_out = 0;
   int syncq[$];

   always #10 clk = ~clk;

   motor_interlock u_motor_interlock (
      .clk(clk), .rst(rst), .lim_lo_raw(lim_lo_raw), .lim_hi_raw(lim_hi_raw),
      .rel_check_en(rel_check_en), .clear(clear), .speed_limit(speed_limit),
      .volt_limit(volt_limit), .cmd_in(cmd_in), .speed_in(speed_in),
      .pos_a(pos_a), .pos_b(pos_b), .cmd_out(cmd_out),
      .fault_word(fault_word), .tripped(tripped)
   );

   task automatic model_edge();
      int lim, trips;
      longint cm, gap;
      if (rst) begin
         syncq = '{0, 0};
         m_fault = 0;
         m_out = 0;
         return;
      end
      lim = syncq.pop_front();
      syncq.push_back({30'd0, lim_hi_raw, lim_lo_raw});
      trips = lim;
      if (int'(speed_in) > int'(speed_limit)) trips |= 4;
      cm = longint'(cmd_in);
      if (cm < 0) cm = -cm;
      if (cm > longint'(volt_limit)) trips |= 8;
      gap = longint'(pos_a) - longint'(pos_b);
      if (gap < 0) gap = -gap;
      if (rel_check_en && gap > 3000) trips |= 16;
      if (clear && trips == 0) m_fault = 0;
      else m_fault = m_fault | trips;
      m_out = (m_fault != 0) ? 0 : int'(cmd_in);
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      vectors++;
      if (int'(fault_word) != m_fault || int'(cmd_out) != m_out ||
          tripped != (m_fault != 0)) begin
         miscompares++;
         $display("FAIL %s: fault=%0d cmd=%0d tripped=%0d expected fault=%0d cmd=%0d tripped=%0d",
                  tag, fault_word, cmd_out, tripped, m_fault, m_out, (m_fault != 0));
      end
   endtask

   initial begin
      #(20 * 200000);
      miscompares++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      syncq = '{0, 0};
      @(negedge clk);
      cmd_in = 16'sd1234;
      step("R1"); step("R1");
      rst = 1'b0;
      // R2 pass-through with varied commands
      cmd_in = 16'sd500;   step("R2");
      cmd_in = -16'sd700;  step("R2");
      cmd_in = 16'sd19999; step("R2");
      // R4 boundary then trip
      speed_in = 16'd1000; step("R4");
      speed_in = 16'd1001; step("R4");
      speed_in = 16'd10;   cmd_in = 16'sd42; step("R7"); step("R7");
      clear = 1'b1; step("R8"); clear = 1'b0;
      cmd_in = 16'sd77; step("R2");
      // R5 boundary, trip, min negative
      cmd_in = 16'sd20000;  step("R5");
      cmd_in = -16'sd20001; step("R5");
      cmd_in = 16'sd5; clear = 1'b1; step("R8"); clear = 1'b0;
      volt_limit = 16'd32767; cmd_in = -16'sd32768; step("R5");
      cmd_in = 16'sd3; clear = 1'b1; step("R8"); clear = 1'b0;
      volt_limit = 16'd32768; cmd_in = -16'sd32768; step("R5");
      volt_limit = 16'd20000; cmd_in = 16'sd9;
      // R6 gap check
      pos_a = 32'sd10000; pos_b = 32'sd7000; step("R6");
      pos_b = 32'sd6999; step("R6");
      pos_b = 32'sd10000; clear = 1'b1; step("R8"); clear = 1'b0;
      pos_a = -32'sd5000; pos_b = -32'sd1999; step("R6");
      pos_a = 32'sd0; pos_b = 32'sd0; clear = 1'b1; step("R8"); clear = 1'b0;
      rel_check_en = 1'b0; pos_a = 32'sd2000000000; pos_b = -32'sd2000000000; step("R6");
      step("R6");
      pos_a = 0; pos_b = 0; rel_check_en = 1'b1;
      // R3 switches via synchronizer, single-cycle pulse
      lim_lo_raw = 1'b1; step("R3");
      lim_lo_raw = 1'b0; step("R3"); step("R3"); step("R3");
      clear = 1'b1; step("R8"); clear = 1'b0;
      lim_hi_raw = 1'b1; step("R3"); step("R3"); step("R3");
      lim_hi_raw = 1'b0; step("R3"); step("R3");
      // R9 clear while speed still over
      clear = 1'b1; speed_in = 16'd5000; step("R9"); step("R9");
      clear = 1'b0; step("R9");
      speed_in = 0; clear = 1'b1; step("R8"); clear = 1'b0;
      // R10 switch arrives with overspeed and a clear in the same edge
      lim_lo_raw = 1'b1; step("R10");
      lim_lo_raw = 1'b0; step("R10");
      speed_in = 16'd2000; clear = 1'b1; cmd_in = 16'sd30000; step("R10");
      clear = 1'b0; speed_in = 0; cmd_in = 16'sd1; step("R11");
      clear = 1'b1; step("R8"); clear = 1'b0;
      cmd_in = -16'sd1; step("R11");
      // R1 reset in the middle of a fault
      speed_in = 16'd9000; step("R4");
      rst = 1'b1; step("R1");
      rst = 1'b0; speed_in = 0; step("R1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule